// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the control registers for a small GPIO controller with a parameterised number of pads. Each pad owns a 16-byte slot in the address space. The slot holds two configuration words, one value word and one spare word. Software reaches every word through a simple synchronous register port: one write strobe, one read strobe, a byte address and 32-bit data. Read data is registered.

From the stored fields the block drives each pad's output enable and output level. It supports push-pull and open-drain drive. It also brings each pad's input level back through a two-flop synchroniser, so that software can read the pin state in the value word. The pull assignment, pull strength and interrupt-routing fields are only stored. Nothing in the block acts on them.

Each pad resolves to one of four drive modes:
- `DRV_HIZ`: the pad is not driven.
- `DRV_PUSH`: the pad is driven to the level bit.
- `DRV_SINK`: open-drain mode, driving low.
- `DRV_RELEASE`: open-drain mode, pad released for a high level.

The mode follows directly from the stored bits. There is no sequencing between modes: any change to the output-enable bit, the function field, the open-drain bit or the level bit moves the pad straight to the mode those bits select.

Top module: `gpio_pad_bank`

## Requirements
- R1: Pad i's slot starts at byte address i*16. Within a slot, configuration word 0 is at offset 0x0, configuration word 1 at 0x4, the value word at 0x8 and the spare word at 0xC. `rdata` shows the addressed word on the cycle after the clock edge that samples `rd_en`.
- R2: After reset, the value word of every pad reads 0x00000006 and all other words read 0. No pad is driven, and `pad_out` is 0.
- R3: Configuration word 0, configuration word 1 and the spare word each store all 32 bits and read them back. Within configuration word 0:
    - bits 2:0 are the function select (0 = GPIO);
    - bits 8:7 are the pull assignment (1 up, 2 down);
    - bits 10:9 are the pull strength (0 = 2k, 1 = 10k, 2 = 20k, 3 = 40k);
    - bit 27 is the direct interrupt route;
    - bit 31 is open-drain enable.
- R4: The value word stores only bits 2:0. Bit 2 is input enable, active low. Bit 1 is output enable, active low. Bit 0 is the level. Bits 31:3 read as 0.
- R5: `pad_oe` can be 1 only when value bit 1 is 0 and the function select is 0.
- R6: In push-pull mode (configuration word 0 bit 31 = 0), while the pad is driven, `pad_out` equals value bit 0.
- R7: In open-drain mode (configuration word 0 bit 31 = 1), `pad_oe` is 1 only while value bit 0 is 0, and `pad_out` is then 0. A written level of 1 releases the pad.
- R8: The read-back of value bit 0 depends on input enable (value bit 2):
    - when bit 2 is 0, it returns `pad_in` of that pad after a two-flop synchroniser;
    - when bit 2 is 1, it returns the last written level.
- R9: Some addresses are unmapped: any address with bits 1:0 not zero, and any slot whose pad index is NUM_PADS or more. Reads of an unmapped address return 0, and writes to one change no register.
- R10: A write changes only the single addressed word of the single addressed pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; data appears on `rdata` one cycle later |
| addr | input | ADDR_W | Byte address (pad index in the upper bits, offset in bits 3:0) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PADS | Pad input levels, asynchronous to `clk` |
| pad_out | output | NUM_PADS | Pad output levels |
| pad_oe | output | NUM_PADS | Pad output enables |

## Verification
The hardest behaviour to reach from the ports is the value-word read-back. Its bit 0 comes from one of two sources: the synchronised pin or the stored level. Which one depends on a separate enable bit, and the synchronised pin lags `pad_in` by two edges.

The stimulus first drives a level of 1 into a pad while holding its pin at 0, so the two sources disagree. It then toggles the input-enable bit. In a separate step it changes the pin, waits out the synchroniser delay and only then issues the read. A wrong source or a wrong depth therefore shows up as a wrong bit 0.

Open-drain release is reached the same way: a level of 1 is written while the output enable is active and the open-drain bit is set.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int WORD_W = 32;

    // Word selector within a 16-byte pad slot (address bits 3:2)
    typedef enum logic [1:0] {
        SLOT_CFG_A = 2'd0,
        SLOT_CFG_B = 2'd1,
        SLOT_VALUE = 2'd2,
        SLOT_SPARE = 2'd3
    } slot_word_e;

    // Drive mode resolved per pad
    typedef enum logic [1:0] {
        DRV_HIZ     = 2'd0,
        DRV_PUSH    = 2'd1,
        DRV_SINK    = 2'd2,
        DRV_RELEASE = 2'd3
    } drive_mode_e;

    localparam int FUNC_W       = 3;
    localparam int OPEN_DRN_BIT = 31;
    localparam int LVL_BIT      = 0;
    localparam int OEN_N_BIT    = 1;
    localparam int IEN_N_BIT    = 2;
    localparam int VAL_W        = 3;
    localparam logic [VAL_W-1:0] VAL_RESET = 3'b110;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
    import gpio_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  slot_word_e        word_sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pin_sync,
    output logic [WORD_W-1:0] cfg_a_rd,
    output logic [WORD_W-1:0] cfg_b_rd,
    output logic [WORD_W-1:0] value_rd,
    output logic [WORD_W-1:0] spare_rd,
    output logic              pad_out,
    output logic              pad_oe
);

    logic [WORD_W-1:0] cfg_a_q;
    logic [WORD_W-1:0] cfg_b_q;
    logic [WORD_W-1:0] spare_q;
    logic [VAL_W-1:0]  val_q;
    drive_mode_e       mode;
    logic              drive_allowed;
    logic              lvl_view;

    // Register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_a_q <= '0;
            cfg_b_q <= '0;
            spare_q <= '0;
            val_q   <= VAL_RESET;
        end else if (wr_sel) begin
            unique case (word_sel)
                SLOT_CFG_A: cfg_a_q <= wdata;
                SLOT_CFG_B: cfg_b_q <= wdata;
                SLOT_VALUE: val_q   <= wdata[VAL_W-1:0];
                SLOT_SPARE: spare_q <= wdata;
            endcase
        end
    end

    // Mode selection
    assign drive_allowed = !val_q[OEN_N_BIT] && (cfg_a_q[FUNC_W-1:0] == '0);

    always_comb begin
        if (!drive_allowed)                 mode = DRV_HIZ;
        else if (!cfg_a_q[OPEN_DRN_BIT])    mode = DRV_PUSH;
        else if (val_q[LVL_BIT])            mode = DRV_RELEASE;
        else                                mode = DRV_SINK;
    end

    // Pad outputs per mode
    always_comb begin
        unique case (mode)
            DRV_HIZ:     begin pad_oe = 1'b0; pad_out = 1'b0;           end
            DRV_PUSH:    begin pad_oe = 1'b1; pad_out = val_q[LVL_BIT]; end
            DRV_SINK:    begin pad_oe = 1'b1; pad_out = 1'b0;           end
            DRV_RELEASE: begin pad_oe = 1'b0; pad_out = 1'b0;           end
        endcase
    end

    // Read-back views
    assign lvl_view = val_q[IEN_N_BIT] ? val_q[LVL_BIT] : pin_sync;
    assign cfg_a_rd = cfg_a_q;
    assign cfg_b_rd = cfg_b_q;
    assign spare_rd = spare_q;
    assign value_rd = {{(WORD_W-VAL_W){1'b0}}, val_q[IEN_N_BIT], val_q[OEN_N_BIT], lvl_view};

    AST_DRIVE_NEEDS_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> (cfg_a_q[FUNC_W-1:0] == '0 && !val_q[OEN_N_BIT]));   // R5
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && cfg_a_q[OPEN_DRN_BIT]) |-> !pad_out);                 // R7
    AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(val_q));                                     // R10

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpio_pad_pkg::*;
#(
    parameter int NUM_PADS  = 6,
    localparam int PAD_IDX_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1,
    localparam int ADDR_W    = PAD_IDX_W + 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);

    localparam logic [PAD_IDX_W:0] PAD_LIMIT = NUM_PADS[PAD_IDX_W:0];

    logic [PAD_IDX_W-1:0] pad_idx;
    slot_word_e           word_sel;
    logic                 addr_hit;
    logic [NUM_PADS-1:0]  wr_strb;
    logic [NUM_PADS-1:0]  pin_sync;
    logic [WORD_W-1:0]    cfg_a_arr [NUM_PADS];
    logic [WORD_W-1:0]    cfg_b_arr [NUM_PADS];
    logic [WORD_W-1:0]    value_arr [NUM_PADS];
    logic [WORD_W-1:0]    spare_arr [NUM_PADS];
    logic [WORD_W-1:0]    rd_mux;

    // Address decode
    assign pad_idx  = addr[ADDR_W-1:4];
    assign word_sel = slot_word_e'(addr[3:2]);
    assign addr_hit = (addr[1:0] == 2'b00) && ({1'b0, pad_idx} < PAD_LIMIT);

    gpio_pad_sync #(.WIDTH(NUM_PADS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
        assign wr_strb[g] = wr_en && addr_hit && (pad_idx == PAD_IDX_W'(g));

        gpio_pad_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_strb[g]),
            .word_sel (word_sel),
            .wdata    (wdata),
            .pin_sync (pin_sync[g]),
            .cfg_a_rd (cfg_a_arr[g]),
            .cfg_b_rd (cfg_b_arr[g]),
            .value_rd (value_arr[g]),
            .spare_rd (spare_arr[g]),
            .pad_out  (pad_out[g]),
            .pad_oe   (pad_oe[g])
        );
    end

    // Read mux
    always_comb begin
        rd_mux = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (addr_hit && pad_idx == PAD_IDX_W'(p)) begin
                unique case (word_sel)
                    SLOT_CFG_A: rd_mux = cfg_a_arr[p];
                    SLOT_CFG_B: rd_mux = cfg_b_arr[p];
                    SLOT_VALUE: rd_mux = value_arr[p];
                    SLOT_SPARE: rd_mux = spare_arr[p];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_ONE_PAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_strb));                                              // R10
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_hit) |=> (rdata == '0));                         // R9
    AST_NO_STROBE_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |-> (wr_strb == '0));                                  // R9

endmodule

// File: tb/gpio_pad_bank_tb.sv
`timescale 1ns/1ps
module gpio_pad_bank_tb;

    localparam int NP = 6;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;
    exp_item_t sb_q[$];
    logic rd_seen = 1'b0;

    always #2 clk = ~clk;

    gpio_pad_bank #(.NUM_PADS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compare registered read data against the scoreboard
    always @(negedge clk) begin
        if (rd_seen && rst_n) begin
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, actual=%h", rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: rdata actual=%h expected=%h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_pad(input int p, input logic eoe, input logic eout, input string tag);
        checks++;
        if (pad_oe[p] !== eoe || pad_out[p] !== eout) begin
            errors++;
            $display("FAIL %s: pad%0d oe/out actual=%b%b expected=%b%b",
                     tag, p, pad_oe[p], pad_out[p], eoe, eout);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R2: reset state
        for (int p = 0; p < NP; p++) chk_pad(p, 1'b0, 1'b0, "R2");
        rd(7'h08, 32'h6, "R2");
        rd(7'h50, 32'h0, "R2");
        rd(7'h5C, 32'h0, "R2");

        // R3 / R1: full-width storage at slot offsets
        wr(7'h10, 32'hA5A5_0F87);
        wr(7'h14, 32'h1234_5678);
        wr(7'h1C, 32'hDEAD_BEEF);
        rd(7'h10, 32'hA5A5_0F87, "R3");
        rd(7'h14, 32'h1234_5678, "R1");
        rd(7'h1C, 32'hDEAD_BEEF, "R3");
        rd(7'h18, 32'h6, "R1");

        // R4: only bits 2:0 of the value word stored; R5/R6 push-pull low
        wr(7'h28, 32'hFFFF_FFF8);
        rd(7'h28, 32'h0, "R4");
        chk_pad(2, 1'b1, 1'b0, "R6");

        // R6 / R8: drive high, pin low, input enabled -> read pin
        wr(7'h28, 32'h1);
        chk_pad(2, 1'b1, 1'b1, "R6");
        rd(7'h28, 32'h0, "R8");
        pad_in[2] = 1'b1;
        idle(2);
        rd(7'h28, 32'h1, "R8");
        pad_in[2] = 1'b0;
        idle(2);
        // R8: input disabled -> last written level
        wr(7'h28, 32'h5);
        rd(7'h28, 32'h5, "R8");
        wr(7'h28, 32'h4);
        pad_in[2] = 1'b1;
        idle(2);
        rd(7'h28, 32'h4, "R8");

        // R5: function select gates drive
        wr(7'h30, 32'h1);
        wr(7'h38, 32'h5);
        chk_pad(3, 1'b0, 1'b0, "R5");
        wr(7'h30, 32'h0);
        chk_pad(3, 1'b1, 1'b1, "R5");
        wr(7'h38, 32'h7);
        chk_pad(3, 1'b0, 1'b0, "R5");

        // R7: open drain
        wr(7'h30, 32'h8000_0000);
        wr(7'h38, 32'h5);
        chk_pad(3, 1'b0, 1'b0, "R7");
        wr(7'h38, 32'h4);
        chk_pad(3, 1'b1, 1'b0, "R7");

        // R9: unmapped accesses
        rd(7'h12, 32'h0, "R9");
        wr(7'h15, 32'hFFFF_FFFF);
        rd(7'h14, 32'h1234_5678, "R9");
        wr(7'h68, 32'h0);
        wr(7'h60, 32'h0);
        rd(7'h68, 32'h0, "R9");
        for (int p = 0; p < NP; p++)
            if (p != 2 && p != 3) chk_pad(p, 1'b0, 1'b0, "R9");

        // R10: isolation between pads and words
        rd(7'h08, 32'h6, "R10");
        rd(7'h10, 32'hA5A5_0F87, "R10");
        rd(7'h34, 32'h0, "R10");

        idle(3);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d reads not returned, expected 0", sb_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule